// File: doc/BRIEF.md
# Reconfigurable Multi-Mode Scan Chain

This block wraps a bank of state flip-flops, split into equal segments, with a scan multiplexer network. When scan is off, every flip-flop loads its functional data input. When scan is on, the flip-flops form shift registers. A two-bit arrangement code sets how the segments are stitched together. The code can give one chain per segment, chains of four consecutive segments, or one chain that runs through the whole bank. One arrangement therefore suits a wide tester, another a narrow tester, and the last serial access through a test access port.

A per-segment skip mask lets a chain pass around any segment. A skipped segment keeps its contents while its chain shifts. This shortens the shift path for patterns whose bits in that segment do not matter. The lanes are plain pins with no valid/ready handshake, because a tester cannot be held back. Each clock with scan enabled moves every active chain by one bit, and no back-pressure exists. The arrangement code and the skip mask may change only while scan is off.

Top module: `recfg_scan_chain`

## Requirements
- R1: With scan_en low, every flip-flop, including those in skipped segments, loads its func_d bit on the next clock. Bit s*SEG_LEN+k of func_d and func_q is position k of segment s.
- R2: With scan_en high, each active segment moves position k to position k+1. Position 0 takes the segment's chain input, and position SEG_LEN-1 is the segment's output.
- R3: Arrangement code 0 gives one chain per segment: lane i enters segment i, and scan_out[i] is the output of segment i.
- R4: Arrangement code 1 gives eight chains. Chain c enters segment 4c at scan_in[c] and runs through segments 4c, 4c+1, 4c+2 and 4c+3 in rising order to scan_out[c]. scan_out lanes 8 to 31 are 0.
- R5: Arrangement code 2 gives one chain from scan_in[0] through segments 0 to 31 in rising order to scan_out[0]. All other scan_out lanes are 0.
- R6: Arrangement code 3 behaves exactly like code 0.
- R7: When seg_bypass[s] is 1, segment s holds its contents during shift, and its chain links the previous active segment, or the lane input, directly to the next one. A chain with n active segments delivers a scan_in bit at its scan_out after n*SEG_LEN clocks.
- R8: If every segment of a chain is skipped, that chain's scan_out equals its scan_in delayed by one clock. No combinational path from scan_in to scan_out exists.
- R9: scan_mode and seg_bypass do not change on a clock where scan_en is high in both that cycle and the previous one.
- R10: While rst_n is low, all flip-flops and the lane delay registers are cleared, so func_q and scan_out read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | 1 = shift, 0 = functional capture |
| scan_mode | input | 2 | Chain arrangement code (0 per-segment, 1 groups of four, 2 single, 3 as 0) |
| seg_bypass | input | 32 | One skip bit per segment |
| scan_in | input | 32 | Serial input per lane |
| scan_out | output | 32 | Serial output per lane |
| func_d | input | 128 | Functional data into the bank |
| func_q | output | 128 | Current bank contents |

## Verification
Shifting through an active segment and holding a skipped neighbour in the same chain happen on the same clock edge. The group-of-four arrangement provokes this with segment 1 skipped and a single 1 pulsed into lane 0. The bench expects the pulse at scan_out[0] after exactly 12 clocks, and 0 one clock earlier. It also expects segment 1's preloaded ones to still read as ones on func_q afterwards. The table walk repeats this overlap on mixed masks, where bypassed bits must survive a full unload while their chain neighbours drain to zero.

// File: rtl/recfg_scan_pkg.sv
package recfg_scan_pkg;
  typedef enum logic [1:0] {
    ARR_WIDE  = 2'b00,
    ARR_GROUP = 2'b01,
    ARR_ONE   = 2'b10,
    ARR_SPARE = 2'b11
  } arr_mode_e;
endpackage

// File: rtl/scan_seg.sv
module scan_seg #(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_en,
  input  logic           skip,
  input  logic           si,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q,
  output logic           so
);
  logic [LEN-1:0] shifted;

  generate
    if (LEN == 1) begin : g_one
      assign shifted = si;
    end else begin : g_many
      assign shifted = {q[LEN-2:0], si};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (!scan_en) q <= d;
    else if (!skip)   q <= shifted;
  end

  assign so = q[LEN-1];

  // R1: functional capture regardless of skip
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> q == $past(d));
  // R7: skipped segment keeps its bits during shift
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && skip) |=> $stable(q));
  // R2: chain input lands in position 0
  a_r2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !skip) |=> q[0] == $past(si));
endmodule

// File: rtl/scan_route.sv
module scan_route
  import recfg_scan_pkg::*;
#(
  parameter int NSEG = 32,
  parameter int GRP  = 4
) (
  input  logic [1:0]      mode,
  input  logic [NSEG-1:0] skip,
  input  logic [NSEG-1:0] lane_in,
  input  logic [NSEG-1:0] seg_out,
  input  logic [NSEG-1:0] lane_dly,
  output logic [NSEG-1:0] seg_in,
  output logic [NSEG-1:0] lane_out
);
  arr_mode_e arr;
  assign arr = arr_mode_e'(mode);

  function automatic logic chain_head(arr_mode_e m, int s);
    case (m)
      ARR_GROUP: return (s % GRP) == 0;
      ARR_ONE:   return s == 0;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic chain_tail(arr_mode_e m, int s);
    case (m)
      ARR_GROUP: return (s % GRP) == GRP - 1;
      ARR_ONE:   return s == NSEG - 1;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic int head_lane(arr_mode_e m, int s);
    case (m)
      ARR_GROUP: return s / GRP;
      ARR_ONE:   return 0;
      default:   return s;
    endcase
  endfunction

  always_comb begin
    logic carry;
    logic live;
    int   lane;
    carry    = 1'b0;
    live     = 1'b0;
    lane     = 0;
    seg_in   = '0;
    lane_out = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (chain_head(arr, s)) begin
        lane  = head_lane(arr, s);
        carry = lane_in[lane];
        live  = 1'b0;
      end
      seg_in[s] = carry;
      if (!skip[s]) begin
        carry = seg_out[s];
        live  = 1'b1;
      end
      if (chain_tail(arr, s))
        lane_out[lane] = live ? carry : lane_dly[lane];
    end
  end
endmodule

// File: rtl/recfg_scan_chain.sv
module recfg_scan_chain #(
  parameter int NSEG    = 32,
  parameter int SEG_LEN = 4,
  parameter int GRP     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scan_en,
  input  logic [1:0]              scan_mode,
  input  logic [NSEG-1:0]         seg_bypass,
  input  logic [NSEG-1:0]         scan_in,
  output logic [NSEG-1:0]         scan_out,
  input  logic [NSEG*SEG_LEN-1:0] func_d,
  output logic [NSEG*SEG_LEN-1:0] func_q
);
  localparam int NGRP = NSEG / GRP;

  logic [NSEG-1:0] seg_in;
  logic [NSEG-1:0] seg_out;
  logic [NSEG-1:0] lane_dly;
  logic            past_ok;

  genvar s;
  generate
    for (s = 0; s < NSEG; s++) begin : g_seg
      scan_seg #(.LEN(SEG_LEN)) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .skip    (seg_bypass[s]),
        .si      (seg_in[s]),
        .d       (func_d[s*SEG_LEN +: SEG_LEN]),
        .q       (func_q[s*SEG_LEN +: SEG_LEN]),
        .so      (seg_out[s])
      );
    end
  endgenerate

  // one-stage lane path used when a chain has no active segment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lane_dly <= '0;
    else if (scan_en) lane_dly <= scan_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  scan_route #(.NSEG(NSEG), .GRP(GRP)) u_route (
    .mode     (scan_mode),
    .skip     (seg_bypass),
    .lane_in  (scan_in),
    .seg_out  (seg_out),
    .lane_dly (lane_dly),
    .seg_in   (seg_in),
    .lane_out (scan_out)
  );

  // R9: configuration frozen while shifting
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && scan_en && $past(scan_en)) |-> ($stable(scan_mode) && $stable(seg_bypass)));
  // R4: idle lanes quiet in group arrangement
  a_r4_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 2'b01) |-> (scan_out[NSEG-1:NGRP] == '0));
  // R5: only lane 0 carries data in the single arrangement
  a_r5_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 2'b10) |-> (scan_out[NSEG-1:1] == '0));
  // R8: fully skipped per-segment chain is a one-clock delay
  a_r8_empty_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(scan_en) && scan_mode == 2'b00 && $past(scan_mode) == 2'b00
     && seg_bypass[0] && $past(seg_bypass[0])) |-> scan_out[0] == $past(scan_in[0]));
endmodule

// File: tb/recfg_scan_chain_test.sv
module recfg_scan_chain_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_en = 1'b0;
  logic [1:0]   scan_mode = 2'b00;
  logic [31:0]  seg_bypass = '0;
  logic [31:0]  scan_in = '0;
  logic [31:0]  scan_out;
  logic [127:0] func_d = '0;
  logic [127:0] func_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  recfg_scan_chain uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_mode(scan_mode),
    .seg_bypass(seg_bypass), .scan_in(scan_in), .scan_out(scan_out),
    .func_d(func_d), .func_q(func_q)
  );

  // {mode, skip mask, preload}
  localparam logic [161:0] VEC [8] = '{
    {2'd0, 32'h0000_0000, 128'h0123456789ABCDEF_FEDCBA9876543210},
    {2'd1, 32'h0000_0000, 128'hA5C3_96F0_0F69_3C5A_1E2D_4B78_8765_4321},
    {2'd2, 32'h0000_0000, 128'hDEADBEEF_0BADF00D_CAFEBABE_12345678},
    {2'd3, 32'h0000_0000, 128'h13579BDF_2468ACE0_FFFF0000_5A5A5A5A},
    {2'd0, 32'h0000_FF00, 128'h7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE},
    {2'd1, 32'h0000_0012, 128'hF00F_0FF0_3333_CCCC_6996_9669_1248_8421},
    {2'd2, 32'hF0F0_F0F0, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0},
    {2'd1, 32'h0000_000F, 128'hFFFF_FFFF_0000_FFFF_1111_2222_4444_8888}
  };

  function automatic logic exp_out(logic [1:0] m, logic [31:0] b, logic [127:0] p,
                                   int lane, int t);
    int first, last, idx;
    if (m == 2'd1) begin
      if (lane >= 8) return 1'b0;
      first = lane * 4; last = first + 3;
    end else if (m == 2'd2) begin
      if (lane != 0) return 1'b0;
      first = 0; last = 31;
    end else begin
      first = lane; last = lane;
    end
    idx = t;
    for (int s = last; s >= first; s--) begin
      if (!b[s]) begin
        if (idx < 4) return p[s*4 + 3 - idx];
        idx -= 4;
      end
    end
    return 1'b0;
  endfunction

  function automatic logic [127:0] keep_mask(logic [31:0] b);
    logic [127:0] k;
    for (int s = 0; s < 32; s++) k[s*4 +: 4] = {4{b[s]}};
    return k;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 func_q", func_q, '0);
    check("R10 scan_out", {96'd0, scan_out}, '0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [1:0]   m;
      logic [31:0]  b;
      logic [127:0] p;
      logic [31:0]  exp;
      int bad;
      {m, b, p} = VEC[v];
      @(negedge clk);
      scan_en = 1'b0; func_d = p; scan_in = '0;
      @(negedge clk);
      scan_mode = m; seg_bypass = b; scan_en = 1'b1;
      bad = 0;
      for (int t = 0; t < 130; t++) begin
        #1;
        for (int l = 0; l < 32; l++) exp[l] = exp_out(m, b, p, l, t);
        if (scan_out !== exp && bad == 0) begin
          bad = 1;
          n_fail++;
          $display("FAIL R2/R3/R4/R5/R6/R7 vec %0d step %0d actual=%h expected=%h",
                   v, t, scan_out, exp);
        end
        @(negedge clk);
      end
      n_run++;
      // R7: skipped segments kept their preload, others drained
      check("R7 hold after unload", func_q, p & keep_mask(b));
      scan_en = 1'b0;
    end

    // R1: capture ignores skip mask
    @(negedge clk);
    scan_en = 1'b0; seg_bypass = '1; func_d = 128'hC0FFEE00_11223344_55667788_99AABBCC;
    @(negedge clk);
    check("R1 capture", func_q, 128'hC0FFEE00_11223344_55667788_99AABBCC);

    // R7 latency with a skipped middle segment (group arrangement)
    func_d = 128'hF0; seg_bypass = '0;
    @(negedge clk);
    scan_mode = 2'd1; seg_bypass = 32'h2; scan_en = 1'b1; scan_in = 32'h1;
    @(negedge clk);
    scan_in = '0;
    repeat (10) @(negedge clk);
    check("R7 not before 12", {127'd0, scan_out[0]}, 128'd0);
    @(negedge clk);
    check("R7 arrives at 12", {127'd0, scan_out[0]}, 128'd1);
    check("R7 skipped seg held", {124'd0, func_q[7:4]}, 128'hF);
    @(negedge clk);
    scan_en = 1'b0;

    // R8: fully skipped single-segment chain
    @(negedge clk);
    scan_mode = 2'd0; seg_bypass = 32'h20; scan_en = 1'b1; scan_in = '0;
    @(negedge clk);
    scan_in = 32'h20;
    #1;
    check("R8 no comb path", {127'd0, scan_out[5]}, 128'd0);
    @(negedge clk);
    scan_in = '0;
    #1;
    check("R8 one clock delay", {127'd0, scan_out[5]}, 128'd1);
    @(negedge clk);
    check("R8 delay clears", {127'd0, scan_out[5]}, 128'd0);
    scan_en = 1'b0;

    // R10: reset mid-run clears everything
    func_d = '1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", func_q, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule